// File: doc/BRIEF.md
# I2C SCL Split-Divisor Clock Generator

This block derives the serial clock of an I2C master from one system clock. Software programs two zero-based divisor fields. One sets how long SCL stays low and the other sets how long it stays high. Each field step is worth eight input clocks, so a full SCL period lasts 8·((low+1)+(high+1)) input cycles, and the SCL frequency is the input frequency divided by that count. When the total divider is odd, the usual split gives the high field the rounded-up half and the low field the rest. The block does not compute that split.

Alongside SCL the generator hands the bit engine a busy flag and four single-cycle ticks:
- an SCL falling-edge tick;
- an SCL rising-edge tick;
- a tick in the middle of every low phase, where SDA may change;
- a tick in the middle of every high phase, where SDA is sampled or a start or stop condition is placed.

A run input starts and stops the clock. While run is low, SCL rests high and all counters are cleared.

Divisor writes go into a staging copy. The generator adopts the staging copy only at the start of a period, so a period that is already running always finishes with the values it started with.

Top module: `scl_divgen`

## Requirements
- R1: After reset, scl_o is 1, busy_o is 0 and all four tick outputs are 0.
- R2: Each SCL low phase lasts exactly 8·(LO+1) input cycles, where LO is div_wdata[15:0] of the divisor in effect.
- R3: Each SCL high phase lasts exactly 8·(HI+1) input cycles, where HI is div_wdata[31:16] of the divisor in effect.
- R4: The low field is bits [15:0] and the high field is bits [31:16] of the divisor word; programming different values into the two fields gives correspondingly different low and high phase lengths.
- R5: tick_fall_o is 1 for exactly the first cycle of every low phase, and tick_rise_o is 1 for exactly the first cycle of every high phase.
- R6: tick_mid_lo_o is 1 in the cycle at index 4·(LO+1) of a low phase, and tick_mid_hi_o is 1 in the cycle at index 4·(HI+1) of a high phase, where the cycle carrying the edge tick is index 0.
- R7: One cycle after run is sampled low, scl_o is 1, busy_o is 0 and no tick is raised for as long as run stays low. Raising run again starts a complete low phase from index 0.
- R8: A divisor write does not alter the period in progress. The new value governs the next period, counted from its low phase. This includes a write sampled on the same edge that ends the final high cycle.
- R9: Field values of 0 give low and high phases of 8 cycles each, with mid ticks at index 4.
- R10: At most one of the four tick outputs is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | 1 = generate SCL, 0 = idle with SCL high |
| div_wr | input | 1 | Write strobe for the divisor word |
| div_wdata | input | 2*DIV_W (32) | Divisor word: [15:0] low field, [31:16] high field |
| scl_o | output | 1 | Generated SCL level |
| busy_o | output | 1 | Generator is running a period |
| tick_rise_o | output | 1 | First cycle of an SCL high phase |
| tick_fall_o | output | 1 | First cycle of an SCL low phase |
| tick_mid_hi_o | output | 1 | Middle of the high phase (sample / start / stop point) |
| tick_mid_lo_o | output | 1 | Middle of the low phase (data change point) |

## Verification
The two functions that can meet in one cycle are a divisor write and the period-boundary load that moves the staging copy into the active divisor. The bench raises div_wr exactly in the last high cycle of a period, so the write and the load are sampled on the same clock edge. The following low and high phases must already follow the new fields. A second write placed early in a low phase must leave that period at its old length and change only the next period.

// File: rtl/scl_divgen_pkg.sv
package scl_divgen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic mid_hi;
        logic mid_lo;
    } tick_t;

endpackage

// File: rtl/scl_div_shadow.sv
module scl_div_shadow #(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [2*DIV_W-1:0] wdata_i,
    input  logic               load_i,
    output logic [DIV_W-1:0]   act_lo_o,
    output logic [DIV_W-1:0]   act_hi_o
);
    localparam int WORD_W = 2 * DIV_W;

    typedef struct packed {
        logic [WORD_W-1:0] staged;
        logic [WORD_W-1:0] active;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (wr_i) begin
            sh_d.staged = wdata_i;
        end
        if (load_i) begin
            // a write landing on the boundary edge is forwarded
            sh_d.active = wr_i ? wdata_i : sh_q.staged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign act_lo_o = sh_q.active[DIV_W-1:0];
    assign act_hi_o = sh_q.active[WORD_W-1:DIV_W];

    // R8: active divisor only moves on a period boundary
    a_r8_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(sh_q.active));

endmodule

// File: rtl/scl_phase_engine.sv
module scl_phase_engine
    import scl_divgen_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] lo_i,
    input  logic [DIV_W-1:0] hi_i,
    output logic             load_o,
    output logic             scl_o,
    output logic             busy_o,
    output tick_t            tick_o
);
    localparam int CNT_W = DIV_W + 4;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             scl;
        tick_t            tk;
    } eng_t;

    eng_t s_d, s_q;

    logic [CNT_W-1:0] len_lo, len_hi, mid_lo, mid_hi, cnt_inc;

    always_comb begin
        len_lo  = (CNT_W'(lo_i) + CNT_W'(1)) << 3;
        len_hi  = (CNT_W'(hi_i) + CNT_W'(1)) << 3;
        mid_lo  = (CNT_W'(lo_i) + CNT_W'(1)) << 2;
        mid_hi  = (CNT_W'(hi_i) + CNT_W'(1)) << 2;
        cnt_inc = s_q.cnt + CNT_W'(1);

        s_d    = s_q;
        s_d.tk = '0;
        load_o = 1'b0;

        if (!run_i) begin
            s_d.ph  = PH_IDLE;
            s_d.cnt = '0;
            s_d.scl = 1'b1;
        end else begin
            case (s_q.ph)
                PH_IDLE: begin
                    s_d.ph      = PH_LOW;
                    s_d.cnt     = '0;
                    s_d.scl     = 1'b0;
                    s_d.tk.fall = 1'b1;
                    load_o      = 1'b1;
                end
                PH_LOW: begin
                    if (s_q.cnt == len_lo - CNT_W'(1)) begin
                        s_d.ph      = PH_HIGH;
                        s_d.cnt     = '0;
                        s_d.scl     = 1'b1;
                        s_d.tk.rise = 1'b1;
                    end else begin
                        s_d.cnt       = cnt_inc;
                        s_d.tk.mid_lo = (cnt_inc == mid_lo);
                    end
                end
                PH_HIGH: begin
                    if (s_q.cnt == len_hi - CNT_W'(1)) begin
                        s_d.ph      = PH_LOW;
                        s_d.cnt     = '0;
                        s_d.scl     = 1'b0;
                        s_d.tk.fall = 1'b1;
                        load_o      = 1'b1;
                    end else begin
                        s_d.cnt       = cnt_inc;
                        s_d.tk.mid_hi = (cnt_inc == mid_hi);
                    end
                end
                default: begin
                    s_d.ph  = PH_IDLE;
                    s_d.cnt = '0;
                    s_d.scl = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph  <= PH_IDLE;
            s_q.cnt <= '0;
            s_q.scl <= 1'b1;
            s_q.tk  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_o  = s_q.scl;
    assign busy_o = (s_q.ph != PH_IDLE);
    assign tick_o = s_q.tk;

    // R10: the four ticks never coincide
    a_r10_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_q.tk));

    // R5: fall tick marks a high-to-low SCL change
    a_r5_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tk.fall |-> (!s_q.scl && $past(s_q.scl)));

    // R5: rise tick marks a low-to-high SCL change
    a_r5_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tk.rise |-> (s_q.scl && !$past(s_q.scl)));

    // R7: dropping run parks the clock high and quiet
    a_r7_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!busy_o && s_q.scl && (s_q.tk == '0)));

    // R2: low-phase counter stays inside its programmed length
    a_r2_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_LOW) |-> (s_q.cnt < len_lo));

    // R3: high-phase counter stays inside its programmed length
    a_r3_high_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_HIGH) |-> (s_q.cnt < len_hi));

endmodule

// File: rtl/scl_divgen.sv
module scl_divgen
    import scl_divgen_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               div_wr,
    input  logic [2*DIV_W-1:0] div_wdata,
    output logic               scl_o,
    output logic               busy_o,
    output logic               tick_rise_o,
    output logic               tick_fall_o,
    output logic               tick_mid_hi_o,
    output logic               tick_mid_lo_o
);
    logic             load;
    logic [DIV_W-1:0] act_lo, act_hi;
    tick_t            ticks;

    scl_div_shadow #(.DIV_W(DIV_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (div_wr),
        .wdata_i  (div_wdata),
        .load_i   (load),
        .act_lo_o (act_lo),
        .act_hi_o (act_hi)
    );

    scl_phase_engine #(.DIV_W(DIV_W)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .lo_i   (act_lo),
        .hi_i   (act_hi),
        .load_o (load),
        .scl_o  (scl_o),
        .busy_o (busy_o),
        .tick_o (ticks)
    );

    assign tick_rise_o   = ticks.rise;
    assign tick_fall_o   = ticks.fall;
    assign tick_mid_hi_o = ticks.mid_hi;
    assign tick_mid_lo_o = ticks.mid_lo;

endmodule

// File: tb/scl_divgen_tb.sv
module scl_divgen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        div_wr = 1'b0;
    logic [31:0] div_wdata = '0;
    logic        scl_o, busy_o, tick_rise_o, tick_fall_o, tick_mid_hi_o, tick_mid_lo_o;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    scl_divgen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .div_wr        (div_wr),
        .div_wdata     (div_wdata),
        .scl_o         (scl_o),
        .busy_o        (busy_o),
        .tick_rise_o   (tick_rise_o),
        .tick_fall_o   (tick_fall_o),
        .tick_mid_hi_o (tick_mid_hi_o),
        .tick_mid_lo_o (tick_mid_lo_o)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_div(input int lo, input int hi);
        @(negedge clk);
        div_wr    = 1'b1;
        div_wdata = {hi[15:0], lo[15:0]};
        @(negedge clk);
        div_wr    = 1'b0;
    endtask

    // Called at a negedge. Waits for a fall tick, then walks one period.
    // wl / wh: index in low / high phase at which to drive a write of wv.
    task automatic measure(input int wl, input int wh, input logic [31:0] wv,
                           output int llen, output int lmid,
                           output int hlen, output int hmid,
                           output int rise, output int fall_next);
        int g = 0;
        while (!tick_fall_o && g < 5000) begin
            @(negedge clk);
            g++;
        end
        llen = 0; lmid = -1; hlen = 0; hmid = -1;
        while (scl_o == 1'b0 && llen < 5000) begin
            if (tick_mid_lo_o) lmid = llen;
            div_wr    = (llen == wl);
            div_wdata = wv;
            llen++;
            @(negedge clk);
        end
        div_wr = 1'b0;
        rise = int'(tick_rise_o);
        while (scl_o == 1'b1 && hlen < 5000) begin
            if (tick_mid_hi_o) hmid = hlen;
            div_wr    = (hlen == wh);
            div_wdata = wv;
            hlen++;
            @(negedge clk);
        end
        div_wr = 1'b0;
        fall_next = int'(tick_fall_o);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 scl", int'(scl_o), 1);
        check("R1 busy", int'(busy_o), 0);
        check("R1 ticks", int'({tick_rise_o, tick_fall_o, tick_mid_hi_o, tick_mid_lo_o}), 0);
    endtask

    task automatic t_pattern(input int lo, input int hi, input string tag);
        int ll, lm, hl, hm, r, f;
        write_div(lo, hi);
        run = 1'b1;
        measure(-1, -1, 32'h0, ll, lm, hl, hm, r, f);
        check({tag, " R2 low length"}, ll, 8 * (lo + 1));
        check({tag, " R3 high length"}, hl, 8 * (hi + 1));
        check({tag, " R4 field split low-high"}, ll - hl, 8 * (lo - hi));
        check({tag, " R6 mid-low index"}, lm, 4 * (lo + 1));
        check({tag, " R6 mid-high index"}, hm, 4 * (hi + 1));
        check({tag, " R5 rise tick"}, r, 1);
        check({tag, " R5 next fall tick"}, f, 1);
        @(negedge clk);
        check({tag, " R5 fall tick one cycle"}, int'(tick_fall_o), 0);
        run = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_stop_restart();
        int ticks_seen = 0;
        int high_seen  = 0;
        int ll, lm, hl, hm, r, f;
        write_div(2, 1);
        run = 1'b1;
        repeat (10) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check("R7 scl high after stop", int'(scl_o), 1);
        check("R7 busy low after stop", int'(busy_o), 0);
        for (int i = 0; i < 20; i++) begin
            ticks_seen += int'(tick_rise_o) + int'(tick_fall_o) + int'(tick_mid_hi_o) + int'(tick_mid_lo_o);
            high_seen  += int'(scl_o);
            @(negedge clk);
        end
        check("R7 no ticks while idle", ticks_seen, 0);
        check("R7 scl held high while idle", high_seen, 20);
        run = 1'b1;
        measure(-1, -1, 32'h0, ll, lm, hl, hm, r, f);
        check("R7 restart full low phase", ll, 24);
        check("R7 restart mid-low", lm, 12);
        run = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_mid_write();
        int ll, lm, hl, hm, r, f;
        write_div(3, 2);
        run = 1'b1;
        measure(3, -1, {16'd4, 16'd1}, ll, lm, hl, hm, r, f);
        check("R8 current low unchanged", ll, 32);
        check("R8 current high unchanged", hl, 24);
        measure(-1, -1, 32'h0, ll, lm, hl, hm, r, f);
        check("R8 next low uses new", ll, 16);
        check("R8 next high uses new", hl, 40);
        run = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_boundary_write();
        int ll, lm, hl, hm, r, f;
        write_div(1, 1);
        run = 1'b1;
        // drive the write during the last high cycle (index 15)
        measure(-1, 15, {16'd0, 16'd2}, ll, lm, hl, hm, r, f);
        check("R8 collision period low old", ll, 16);
        check("R8 collision period high old", hl, 16);
        measure(-1, -1, 32'h0, ll, lm, hl, hm, r, f);
        check("R8 collision next low new", ll, 24);
        check("R8 collision next high new", hl, 8);
        check("R9 zero high mid index", hm, 4);
        run = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pattern(2, 5, "A");
        t_pattern(5, 1, "B");
        t_pattern(0, 0, "R9 zero");
        t_stop_restart();
        t_mid_write();
        t_boundary_write();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule